// File: doc/BRIEF.md
# Fractional Rate Incrementor

This block advances a time-base counter at a fixed average rate whichever of two source clocks drives it. Each clock carries a 12-bit accumulator. On every cycle the accumulator adds a numerator. When the sum reaches a shared 12-bit denominator, the denominator is subtracted and the counter steps by one. The counter therefore advances by numerator/denominator per source clock on average.

Two numerators are held, one for each source clock, and a mode input picks the one in use. Software can also copy an externally supplied coarse count into the running counter. It does this by writing a rising edge on a control bit of the second register. Software reaches both registers through a simple write port and a read port with combinational readback.

Top module: `frac_tick_gen`

## Requirements
- R1: After reset, register 0 reads 0x0659_0208, register 1 reads 0x0000_0CB2, and `count_out` is 0.
- R2: Register 0 holds the main-clock numerator in bits 11:0 and the low-power numerator in bits 27:16. Register 1 holds the denominator in bits 11:0 and the reload control in bit 16. All other bits read 0. `wr_addr`/`rd_addr` 0 selects register 0 and 1 selects register 1.
- R3: With `clk_mode_lp` low, k cycles after a reload of value C the counter equals C + floor(k·N/D), where N is the main numerator and D is the denominator, for N < D.
- R4: With `clk_mode_lp` high, the same relation holds using the low-power numerator.
- R5: A write to register 1 that moves bit 16 from 0 to 1 loads `coarse_val` into the counter on that write's clock edge and empties the accumulator.
- R6: Writing 1 to bit 16 while it already holds 1 does not reload. The bit reads back as last written, so a new reload needs a write of 0 followed by a write of 1.
- R7: When a reload and an increment fall on the same edge, the counter takes the coarse value alone.
- R8: A selected numerator greater than or equal to the denominator (including a denominator of 0) steps the counter on every cycle. The counter wraps modulo 2^CNT_W.
- R9: Outside a reload, the counter changes by 0 or 1 per cycle.
- R10: With the reset configuration, main mode yields floor(k·520/3250) steps in k cycles and low-power mode yields floor(k/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Active source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read register select |
| rd_data | output | 32 | Combinational read data |
| clk_mode_lp | input | 1 | 1 selects the low-power numerator, 0 the main numerator |
| coarse_val | input | CNT_W | Value copied into the counter on reload |
| count_out | output | CNT_W | Time-base counter |

## Verification
A register write takes effect on the edge that samples it. A reload therefore shows `coarse_val` on `count_out` immediately after that edge. Each further edge adds floor-rate steps, so after k edges the bench expects C + floor(k·N/D), or C + k when saturated. Readback is combinational and is checked in the same half cycle as the request. Inputs are driven and outputs sampled on the falling edge, so every check reads a value settled by exactly the counted number of rising edges.

// File: rtl/frac_pkg.sv
package frac_pkg;
  localparam int REG_W        = 32;
  localparam int NUM_W        = 12;
  localparam int NUM_LP_LSB   = 16;
  localparam int RELOAD_BIT   = 16;
  localparam logic [NUM_W-1:0] RST_NUM_MAIN = 12'h208;
  localparam logic [NUM_W-1:0] RST_NUM_LP   = 12'h659;
  localparam logic [NUM_W-1:0] RST_DEN      = 12'hCB2;

  typedef struct packed {
    logic [NUM_W-1:0] num_main;
    logic [NUM_W-1:0] num_lp;
    logic [NUM_W-1:0] den;
    logic             reload;
  } frac_cfg_t;
endpackage

// File: rtl/frac_rst_sync.sv
module frac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n_in) begin
        if (!rst_n_in) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= 1'b1;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/frac_cfg_regs.sv
module frac_cfg_regs
  import frac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output frac_cfg_t        cfg,
  output logic             reload_pulse
);
  frac_cfg_t cfg_q, cfg_d;
  logic      wr_num, wr_den;

  assign wr_num = wr_en && !wr_addr;
  assign wr_den = wr_en &&  wr_addr;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_num) begin
      cfg_d.num_main = wr_data[NUM_W-1:0];
      cfg_d.num_lp   = wr_data[NUM_LP_LSB +: NUM_W];
    end
    if (wr_den) begin
      cfg_d.den    = wr_data[NUM_W-1:0];
      cfg_d.reload = wr_data[RELOAD_BIT];
    end
  end

  // Reload fires only when the stored bit goes from 0 to 1.
  assign reload_pulse = wr_den && wr_data[RELOAD_BIT] && !cfg_q.reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.num_main <= RST_NUM_MAIN;
      cfg_q.num_lp   <= RST_NUM_LP;
      cfg_q.den      <= RST_DEN;
      cfg_q.reload   <= 1'b0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (!rd_addr) begin
      rd_data[NUM_W-1:0]              = cfg_q.num_main;
      rd_data[NUM_LP_LSB +: NUM_W]    = cfg_q.num_lp;
    end else begin
      rd_data[NUM_W-1:0]              = cfg_q.den;
      rd_data[RELOAD_BIT]             = cfg_q.reload;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int NUM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_W-1:0] num,
  input  logic [NUM_W-1:0] den,
  input  logic             clear,
  output logic             inc
);
  logic [NUM_W-1:0] acc_q, acc_d;
  logic [NUM_W:0]   sum, diff;
  logic             saturate;

  assign saturate = (num >= den);
  assign sum      = {1'b0, acc_q} + {1'b0, num};
  assign diff     = sum - {1'b0, den};

  always_comb begin
    acc_d = acc_q;
    inc   = 1'b0;
    if (saturate) begin
      inc   = 1'b1;
      acc_d = '0;
    end else if (sum >= {1'b0, den}) begin
      inc   = 1'b1;
      acc_d = diff[NUM_W-1:0];
    end else begin
      acc_d = sum[NUM_W-1:0];
    end
    if (clear) acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/frac_time_counter.sv
module frac_time_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             cnt_en;

  assign cnt_en = load || inc;

  always_comb begin
    if (load) count_d = load_val;
    else      count_d = count_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import frac_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             rd_addr,
  output logic [31:0]      rd_data,
  input  logic             clk_mode_lp,
  input  logic [CNT_W-1:0] coarse_val,
  output logic [CNT_W-1:0] count_out
);
  logic             rst_sync_n;
  frac_cfg_t        cfg;
  logic             reload_pulse;
  logic [NUM_W-1:0] num_main, num_lp, den, num_sel;
  logic             inc;

  frac_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  frac_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg(cfg), .reload_pulse(reload_pulse)
  );

  assign num_main = cfg.num_main;
  assign num_lp   = cfg.num_lp;
  assign den      = cfg.den;
  assign num_sel  = clk_mode_lp ? num_lp : num_main;

  frac_accum #(.NUM_W(NUM_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .num(num_sel), .den(den),
    .clear(reload_pulse), .inc(inc)
  );

  frac_time_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .inc(inc), .load(reload_pulse),
    .load_val(coarse_val), .count(count_out)
  );
endmodule

// File: rtl/frac_tick_gen_chk.sv
module frac_tick_gen_chk #(
  parameter int CNT_W = 32,
  parameter int NUM_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reload_pulse,
  input logic             clk_mode_lp,
  input logic [NUM_W-1:0] num_main,
  input logic [NUM_W-1:0] num_lp,
  input logic [NUM_W-1:0] den,
  input logic [CNT_W-1:0] coarse_val,
  input logic [CNT_W-1:0] count_out
);
  logic [NUM_W-1:0] num_used;
  assign num_used = clk_mode_lp ? num_lp : num_main;

  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |=> count_out == $past(coarse_val)); // R5

  AST_RELOAD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |=> !reload_pulse); // R6

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_pulse |=> (count_out == $past(count_out) ||
                       count_out == $past(count_out) + 1'b1)); // R9

  AST_SATURATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_pulse && num_used >= den) |=> count_out == $past(count_out) + 1'b1); // R8

  AST_ZERO_NUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_pulse && num_used == '0 && den != '0) |=> $stable(count_out)); // R3
endmodule

bind frac_tick_gen frac_tick_gen_chk #(.CNT_W(CNT_W), .NUM_W(frac_pkg::NUM_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reload_pulse(reload_pulse),
  .clk_mode_lp(clk_mode_lp), .num_main(num_main), .num_lp(num_lp), .den(den),
  .coarse_val(coarse_val), .count_out(count_out)
);

// File: tb/test_frac_tick_gen.sv
module test_frac_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en, wr_addr, rd_addr, clk_mode_lp;
  logic [31:0]      wr_data, rd_data;
  logic [CNT_W-1:0] coarse_val, count_out;
  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_tick_gen #(.CNT_W(CNT_W)) i_frac_tick_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .clk_mode_lp(clk_mode_lp), .coarse_val(coarse_val), .count_out(count_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(logic addr, logic [31:0] data);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] den_word(logic rl, logic [11:0] d);
    return {15'd0, rl, 4'd0, d};
  endfunction

  // Clears bit 16, then sets it: count equals c right after.
  task automatic do_reload(logic [31:0] c, logic [11:0] d);
    coarse_val = c;
    do_write(1'b1, den_word(1'b0, d));
    do_write(1'b1, den_word(1'b1, d));
  endtask

  function automatic logic [31:0] expect_cnt(logic [31:0] c, int k, int num, int d);
    if (num >= d) return c + k;
    return c + (k * num) / d;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    rd_addr = 1'b0; clk_mode_lp = 1'b0; coarse_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 count", count_out, 32'd0);
    rd_addr = 1'b0; #1 check("R1 reg0", rd_data, 32'h0659_0208);
    rd_addr = 1'b1; #1 check("R1 reg1", rd_data, 32'h0000_0CB2);
    repeat (3) @(negedge clk);

    // R10: reset rates, main then low-power
    do_reload(32'd5000, 12'hCB2);
    for (int k = 0; k <= 60; k++) begin
      check("R10 main", count_out, expect_cnt(32'd5000, k, 520, 3250));
      @(negedge clk);
    end
    clk_mode_lp = 1'b1;
    do_reload(32'd700, 12'hCB2);
    for (int k = 0; k <= 40; k++) begin
      check("R10 lp", count_out, 32'd700 + k/2);
      @(negedge clk);
    end

    // R2: field positions and reserved bits
    do_write(1'b0, 32'hFFFF_FFFF);
    rd_addr = 1'b0; #1 check("R2 reg0", rd_data, 32'h0FFF_0FFF);
    do_write(1'b1, 32'hFFFE_FFFF);
    rd_addr = 1'b1; #1 check("R2 reg1", rd_data, 32'h0000_0FFF);

    // R3/R4/R7/R8: sweep over small numerators and denominators in both modes
    for (int m = 0; m < 2; m++) begin
      clk_mode_lp = m[0];
      for (int d = 1; d <= 12; d++) begin
        for (int n = 0; n <= d + 1; n++) begin
          if (m == 0) do_write(1'b0, {20'd0, n[11:0]});
          else        do_write(1'b0, {4'd0, n[11:0], 16'd0});
          do_reload(32'd1000 * d + n, d[11:0]);
          for (int k = 0; k <= 24; k++) begin
            if (k == 0 && n >= d)
              check("R7 reload wins", count_out, 32'd1000 * d + n);
            else if (n >= d)
              check("R8 saturate", count_out, expect_cnt(32'd1000 * d + n, k, n, d));
            else if (m == 0)
              check("R3 main mode", count_out, expect_cnt(32'd1000 * d + n, k, n, d));
            else
              check("R4 lp mode", count_out, expect_cnt(32'd1000 * d + n, k, n, d));
            @(negedge clk);
          end
        end
      end
    end

    // R8: denominator 0 saturates and the counter wraps
    clk_mode_lp = 1'b0;
    do_write(1'b0, 32'd0);
    do_reload(32'hFFFF_FFFE, 12'd0);
    check("R8 wrap k0", count_out, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    check("R8 wrap k3", count_out, 32'd1);

    // R5/R6: re-writing 1 does nothing, 0 then 1 reloads
    do_write(1'b0, 32'd1);
    do_reload(32'd300, 12'd2);
    check("R5 load", count_out, 32'd300);
    repeat (10) @(negedge clk);
    coarse_val = 32'd9999;
    do_write(1'b1, den_word(1'b1, 12'd2));
    check("R6 no reload", count_out, 32'd300 + 11/2);
    rd_addr = 1'b1; #1 check("R6 readback", rd_data, den_word(1'b1, 12'd2));
    do_write(1'b1, den_word(1'b0, 12'd2));
    check("R6 cleared", count_out, 32'd300 + 12/2);
    do_write(1'b1, den_word(1'b1, 12'd2));
    check("R5 reload again", count_out, 32'd9999);
    repeat (4) @(negedge clk);
    check("R5 acc cleared", count_out, 32'd10001);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule